// File: doc/BRIEF.md
# Fixed-Point Square Root Refinement Unit

This unit turns an integer square root estimate into a fixed-point root with 16 fractional bits. The caller supplies a 16-bit unsigned value X and the integer nearest to its square root, R. The unit forms the signed residue Y = X − R² itself. When the residue is non-zero, it computes a first-order step d = |Y|/(2R). It adds that step to R when X lies above R² and subtracts it when X lies below. It then removes a single second-order term d²/(2s), where s is the stepped value. This closed-form correction replaces repeated Newton iterations.

Both quotients come from one shared restoring divider that yields one quotient bit per clock. An operation is launched with a one-cycle `start` while the unit is idle. The unit latches the operands on that edge and raises `busy` until the result is ready. `done` is high for exactly one cycle, and `root_out` holds the result until the next operation finishes. When the residue is zero, the divider is skipped and the integer root comes back after a single cycle.

Top module: `sqrt_refine`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0 and `root_out` is 0.
- R2: `start` sampled high at a rising edge while `busy` is 0 accepts an operation and latches `x_in` and `root_in` on that edge. Later changes on those inputs do not alter the result.
- R3: `start` sampled while `busy` is 1 is ignored. It produces no extra `done`, it does not change the operands in flight, and `busy` stays 1.
- R4: The residue is Y = X − R², with sign flag 0 when X ≥ R² and 1 when X < R². With flag 0 the step is added, s = R·2^16 + d. With flag 1 it is subtracted, s = R·2^16 − d.
- R5: The step is d = floor(|Y|·2^16 / (2R)), a value with 16 fractional bits.
- R6: The result is s − floor(d² / (2s)), saturated at 2^24 − 1. `root_out` has 8 integer bits [23:16] and 16 fractional bits [15:0], and every quotient is truncated.
- R7: When Y = 0, `root_out` equals R·2^16 exactly, with bits [15:0] all zero. In that case `done` rises after the first rising edge following the accepting edge.
- R8: When Y ≠ 0, `done` rises after the 100th rising edge following the accepting edge (2·48 divider steps plus 4 sequencing cycles).
- R9: `done` is high for a single cycle. `root_out` keeps its value until the next result.
- R10: When R is the nearest integer root of X (|Y| ≤ R) and X > 0, the result differs from √X by less than 1% of √X.
- R11: Both quotients come from one restoring divider that develops one bit per clock over 48 steps per division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Launch an operation while idle |
| x_in | input | 16 | Unsigned operand X |
| root_in | input | 9 | Integer root estimate R (1..256; 0 only with X = 0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| root_out | output | 24 | Root, 8 integer and 16 fractional bits |

## Verification
The two results have fixed due times. A zero-residue result is due one rising edge after acceptance, and every other result is due one hundred edges after acceptance. The monitor therefore records the negative edge just before each accepting edge. It requires `done` at exactly that count plus the due time plus one, and it fails any `done` that arrives with no operation pending. Values are compared bit for bit with an integer model of the truncating formula. For nearest-root operands, the bench also checks the result against a real-valued square root for the 1% bound.

// File: rtl/sqrt_refine_pkg.sv
package sqrt_refine_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV1,
    ST_CORR,
    ST_DIV2
  } refine_state_t;

endpackage

// File: rtl/sqrt_refine_residue.sv
module sqrt_refine_residue #(
  parameter int IN_W   = 16,
  parameter int ROOT_W = 9,
  parameter int RES_W  = 17
) (
  input  logic [IN_W-1:0]   x,
  input  logic [ROOT_W-1:0] root,
  output logic [RES_W-1:0]  mag,
  output logic              neg,
  output logic              zero
);

  localparam int SQ_W = 2 * ROOT_W;

  logic [SQ_W-1:0] sq;
  logic [SQ_W-1:0] x_ext;
  logic [SQ_W-1:0] diff;

  assign sq    = {{ROOT_W{1'b0}}, root} * {{ROOT_W{1'b0}}, root};
  assign x_ext = {{(SQ_W-IN_W){1'b0}}, x};

  always_comb begin
    neg  = x_ext < sq;
    zero = x_ext == sq;
    diff = neg ? (sq - x_ext) : (x_ext - sq);
    mag  = diff[RES_W-1:0];
  end

endmodule

// File: rtl/sqrt_refine_div.sv
module sqrt_refine_div #(
  parameter int DVD_W = 48,
  parameter int DVS_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);

  localparam int CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic [DVS_W-1:0] rem_q, rem_n;
  logic [DVS_W-1:0] dvs_q, dvs_n;
  logic [DVD_W-1:0] quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             ld_en, stp_en;
  logic [DVS_W:0]   rem_sh;
  logic             fits;

  assign ld_en  = go && !busy_q;
  assign stp_en = busy_q;
  assign rem_sh = {rem_q, quo_q[DVD_W-1]};
  assign fits   = rem_sh >= {1'b0, dvs_q};

  always_comb begin
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    quo_n  = quo_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (ld_en) begin
      rem_n  = '0;
      dvs_n  = divisor;
      quo_n  = dividend;
      cnt_n  = LAST;
      busy_n = 1'b1;
    end else if (stp_en) begin
      rem_n = fits ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];
      quo_n = {quo_q[DVD_W-2:0], fits};
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

  // R11
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dvs_q != '0) |-> (rem_q < dvs_q));

  // R11
  div_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

endmodule

// File: rtl/sqrt_refine_blend.sv
module sqrt_refine_blend #(
  parameter int ROOT_W = 9,
  parameter int FRAC_W = 16,
  parameter int D_W    = 24,
  parameter int S_W    = 25,
  parameter int OUT_W  = 24,
  parameter int DVD_W  = 48
) (
  input  logic [ROOT_W-1:0] root,
  input  logic [D_W-1:0]    step,
  input  logic              neg,
  input  logic [S_W-1:0]    stepped,
  input  logic [DVD_W-1:0]  corr,
  output logic [S_W-1:0]    stepped_calc,
  output logic [OUT_W-1:0]  result_calc
);

  logic [S_W-1:0] base;
  logic [S_W-1:0] step_ext;
  logic [S_W-1:0] diff;
  logic           corr_big;

  assign base     = {root, {FRAC_W{1'b0}}};
  assign step_ext = {{(S_W-D_W){1'b0}}, step};
  assign corr_big = (|corr[DVD_W-1:S_W]) || (corr[S_W-1:0] > stepped);

  always_comb begin
    stepped_calc = neg ? (base - step_ext) : (base + step_ext);
    diff         = corr_big ? '0 : (stepped - corr[S_W-1:0]);
    if (|diff[S_W-1:OUT_W]) begin
      result_calc = '1;
    end else begin
      result_calc = diff[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sqrt_refine.sv
module sqrt_refine #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [IN_W-1:0]               x_in,
  input  logic [IN_W/2:0]               root_in,
  output logic                          busy,
  output logic                          done,
  output logic [IN_W/2+FRAC_W-1:0]      root_out
);
  import sqrt_refine_pkg::*;

  localparam int ROOT_W = IN_W / 2 + 1;
  localparam int OUT_W  = IN_W / 2 + FRAC_W;
  localparam int RES_W  = IN_W + 1;
  localparam int D_W    = OUT_W;
  localparam int S_W    = OUT_W + 1;
  localparam int DVD_W  = 2 * D_W;
  localparam int DVS_W  = S_W + 1;

  refine_state_t     state_q, state_n;
  logic [IN_W-1:0]   x_q, x_n;
  logic [ROOT_W-1:0] root_q, root_n;
  logic              neg_q, neg_n;
  logic [D_W-1:0]    d_q, d_n;
  logic [S_W-1:0]    s_q, s_n;
  logic [OUT_W-1:0]  res_q, res_n;
  logic              done_q, done_n;

  logic              accept_en;
  logic [RES_W-1:0]  r_mag;
  logic              r_neg, r_zero;
  logic              div_go, div_busy, div_done;
  logic [DVD_W-1:0]  div_dvd, div_quo;
  logic [DVS_W-1:0]  div_dvs;
  logic [DVD_W-1:0]  d_sq;
  logic [S_W-1:0]    s_calc;
  logic [OUT_W-1:0]  res_calc;

  sqrt_refine_residue #(.IN_W(IN_W), .ROOT_W(ROOT_W), .RES_W(RES_W)) u_residue (
    .x    (x_q),
    .root (root_q),
    .mag  (r_mag),
    .neg  (r_neg),
    .zero (r_zero)
  );

  sqrt_refine_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  sqrt_refine_blend #(.ROOT_W(ROOT_W), .FRAC_W(FRAC_W), .D_W(D_W), .S_W(S_W),
                      .OUT_W(OUT_W), .DVD_W(DVD_W)) u_blend (
    .root         (root_q),
    .step         (d_q),
    .neg          (neg_q),
    .stepped      (s_q),
    .corr         (div_quo),
    .stepped_calc (s_calc),
    .result_calc  (res_calc)
  );

  assign d_sq      = {{D_W{1'b0}}, d_q} * {{D_W{1'b0}}, d_q};
  assign accept_en = start && (state_q == ST_IDLE);

  always_comb begin
    state_n = state_q;
    x_n     = x_q;
    root_n  = root_q;
    neg_n   = neg_q;
    d_n     = d_q;
    s_n     = s_q;
    res_n   = res_q;
    done_n  = 1'b0;
    div_go  = 1'b0;
    div_dvd = '0;
    div_dvs = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept_en) begin
          x_n     = x_in;
          root_n  = root_in;
          state_n = ST_PREP;
        end
      end
      ST_PREP: begin
        neg_n = r_neg;
        if (r_zero) begin
          res_n   = OUT_W'({root_q, {FRAC_W{1'b0}}});
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          div_go  = 1'b1;
          div_dvd = {{(DVD_W-RES_W-FRAC_W){1'b0}}, r_mag, {FRAC_W{1'b0}}};
          div_dvs = {{(DVS_W-ROOT_W-1){1'b0}}, root_q, 1'b0};
          state_n = ST_DIV1;
        end
      end
      ST_DIV1: begin
        if (div_done) begin
          d_n     = div_quo[D_W-1:0];
          state_n = ST_CORR;
        end
      end
      ST_CORR: begin
        s_n     = s_calc;
        div_go  = 1'b1;
        div_dvd = d_sq;
        div_dvs = {s_calc, 1'b0};
        state_n = ST_DIV2;
      end
      ST_DIV2: begin
        if (div_done) begin
          res_n   = res_calc;
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      root_q  <= '0;
      neg_q   <= 1'b0;
      d_q     <= '0;
      s_q     <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      x_q     <= x_n;
      root_q  <= root_n;
      neg_q   <= neg_n;
      d_q     <= d_n;
      s_q     <= s_n;
      res_q   <= res_n;
      done_q  <= done_n;
    end
  end

  assign busy     = state_q != ST_IDLE;
  assign done     = done_q;
  assign root_out = res_q;

  // R3
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(x_q) && $stable(root_q)));

  // R7
  exact_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP && r_zero) |=>
      (done_q && ({1'b0, res_q} == {$past(root_q), {FRAC_W{1'b0}}})));

  // R4
  add_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !neg_q) |-> ({1'b0, res_q} >= {root_q, {FRAC_W{1'b0}}}));

  // R4
  sub_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && neg_q) |-> ({1'b0, res_q} <= {root_q, {FRAC_W{1'b0}}}));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11
  one_division_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

endmodule

// File: tb/sqrt_refine_tb_top.sv
module sqrt_refine_tb_top;

  localparam int K_ZERO = 1;
  localparam int K_FULL = 2 * 48 + 4;

  typedef struct {
    int x;
    int r;
    int expv;
    int k;
    bit near;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] x_in;
  logic [8:0]  root_in;
  logic        busy;
  logic        done;
  logic [23:0] root_out;

  item_t exp_q[$];
  int    acc_q[$];
  int    n_chk;
  int    n_err;
  int    ncyc;
  bit    finished;

  sqrt_refine dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .x_in     (x_in),
    .root_in  (root_in),
    .busy     (busy),
    .done     (done),
    .root_out (root_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic int nearest_root(int x);
    int r;
    r = int'($floor($sqrt(real'(x))));
    while (r * r > x) r--;
    while ((r + 1) * (r + 1) <= x) r++;
    if (x - r * r > r) r++;
    return r;
  endfunction

  function automatic int model(int x, int r);
    longint base, y, mag, d, s, e, o;
    base = longint'(r) <<< 16;
    y    = longint'(x) - longint'(r) * r;
    if (y == 0) return int'(base);
    mag = (y < 0) ? -y : y;
    d   = (mag <<< 16) / (2 * longint'(r));
    s   = (y < 0) ? base - d : base + d;
    e   = (d * d) / (2 * s);
    o   = s - e;
    if (o > 64'd16777215) o = 16777215;
    if (o < 0) o = 0;
    return int'(o);
  endfunction

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) begin
      @(posedge clk);
      #2;
    end
  endtask

  // R2: operands scrambled right after acceptance must not matter
  task automatic run_op(input int x, input int r, input bit near);
    item_t it;
    wait_idle();
    it.x    = x;
    it.r    = r;
    it.expv = model(x, r);
    it.k    = (x == r * r) ? K_ZERO : K_FULL;
    it.near = near;
    exp_q.push_back(it);
    start   = 1'b1;
    x_in    = 16'(x);
    root_in = 9'(r);
    @(posedge clk);
    #2;
    start   = 1'b0;
    x_in    = 16'(x * 7 + 1234);
    root_in = 9'(r + 77);
    wait_idle();
  endtask

  // Scoreboard monitor
  initial begin
    ncyc = 0;
    forever begin
      @(negedge clk);
      ncyc++;
      if (rst_n && start && !busy) acc_q.push_back(ncyc);
      if (rst_n && done) begin
        if (exp_q.size() == 0 || acc_q.size() == 0) begin
          check(1'b0, "R3/R9", "done with no pending operation", 1, 0);
        end else begin
          item_t it;
          int    t0;
          real   got, tru, err;
          it = exp_q.pop_front();
          t0 = acc_q.pop_front();
          check(root_out == 24'(it.expv), (it.k == K_ZERO) ? "R7" : "R4/R5/R6",
                $sformatf("value x=%0d r=%0d", it.x, it.r), root_out, it.expv);
          check(ncyc == t0 + it.k + 1, (it.k == K_ZERO) ? "R7" : "R8/R11",
                $sformatf("done timing x=%0d", it.x), ncyc - t0 - 1, it.k);
          if (it.near && it.x > 0) begin
            got = real'(root_out) / 65536.0;
            tru = $sqrt(real'(it.x));
            err = (got > tru) ? got - tru : tru - got;
            check(err < 0.01 * tru, "R10", $sformatf("error bound x=%0d", it.x),
                  longint'(got * 65536.0), longint'(tru * 65536.0));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    n_chk    = 0;
    n_err    = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    start    = 1'b0;
    x_in     = '0;
    root_in  = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: state during reset
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(root_out == 24'd0, "R1", "root_out in reset", root_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check(busy == 1'b0 && done == 1'b0 && root_out == 24'd0, "R1",
          "outputs after release", {busy, done, root_out}, 0);

    // R7 R4 R10: small operands, perfect squares and both residue signs
    for (int x = 0; x < 256; x++) run_op(x, nearest_root(x), 1'b1);

    // R6 R10: spread across the range
    for (int i = 0; i < 400; i++) begin
      int x;
      x = (i * 163 + 37) % 65536;
      run_op(x, nearest_root(x), 1'b1);
    end

    // R4 R6: corners at the top of the range, including a 9-bit root
    run_op(65535, nearest_root(65535), 1'b1);
    run_op(65280, nearest_root(65280), 1'b1);
    run_op(65281, nearest_root(65281), 1'b1);
    run_op(65025, 255, 1'b1);
    run_op(1, 1, 1'b1);

    // R5 R6: floor roots, step up to one full unit
    run_op(3, 1, 1'b0);
    run_op(8, 2, 1'b0);
    run_op(1000, 31, 1'b0);

    // R3: start while busy is ignored
    begin
      item_t it;
      wait_idle();
      it.x = 50000; it.r = nearest_root(50000);
      it.expv = model(it.x, it.r); it.k = K_FULL; it.near = 1'b1;
      exp_q.push_back(it);
      start = 1'b1; x_in = 16'(it.x); root_in = 9'(it.r);
      @(posedge clk);
      #2;
      start = 1'b0;
      repeat (10) @(posedge clk);
      #2;
      check(busy == 1'b1, "R3", "busy before ignored start", busy, 1);
      start = 1'b1; x_in = 16'd12345; root_in = 9'd111;
      @(posedge clk);
      #2;
      start = 1'b0;
      check(busy == 1'b1, "R3", "busy after ignored start", busy, 1);
      wait_idle();
      // R9: result holds and no further done
      repeat (8) @(posedge clk);
      #2;
      check(root_out == 24'(it.expv), "R9", "result held", root_out, it.expv);
      check(done == 1'b0, "R9", "done stays low", done, 0);
    end

    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule